// File: doc/BRIEF.md
# Channel-Programmable Dual-Modulus Clock Divider

This block divides a fast oscillator clock down to a reference-rate pulse for the feedback path of a digital phase-locked loop. A small prescaler divides the oscillator clock by either 4 or 5, selected by a modulus-control bit. A 6-bit program counter counts completed prescaler cycles, so one output period spans 64 prescaler cycles.

The program counter starts each period with the prescaler dividing by 5. The counter is compared bit by bit, using XNOR gates whose results are ANDed together, against a target made of a leading 1 and the 5-bit channel number. On a match, a set/reset state bit moves the prescaler to divide-by-4. When the counter wraps back to zero, the state bit is cleared and divide-by-5 returns. A period therefore holds 32+chan cycles of 5 clocks and 32-chan cycles of 4 clocks, for a ratio of 288+chan. The channel number is captured only at the wrap, so each period is divided according to a single channel value.

Top module: `moddiv_channel_divider`

## Requirements
- R1: While reset is applied and on the first clock after it is released, `div_out` is 0 and `mc` is 1 (divide-by-5 selected).
- R2: The prescaler completes a cycle after 5 input clocks while `mc` is 1 and after 4 input clocks while `mc` is 0.
- R3: The program counter advances by one at the end of each prescaler cycle, holds otherwise, and wraps from 63 to 0.
- R4: `mc` falls one clock after the program counter reaches the target {1, channel}. This gives exactly 161+5*chan clocks with `mc`=1 in every output period.
- R5: `mc` returns to 1 on the clock where the program counter wraps to 0.
- R6: The spacing between consecutive `div_out` pulses is 288+chan input clocks, where chan is the captured channel.
- R7: `div_out` is high for exactly one input clock per period, on the first clock of the period, when the program counter is 0.
- R8: `chan` is captured only at the wrap. A change during a period has no effect on that period's length or its `mc` pattern.
- R9: The captured channel resets to 0, so the first pulse after reset arrives on the 288th clock edge after release.
- R10: The extreme channels work: chan=0 gives 288 clocks, and chan=31 (target 63) gives 319 clocks with a single divide-by-4 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock to be divided |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan | input | 5 | Channel number, captured at each wrap |
| div_out | output | 1 | One-clock pulse at the start of each divided period |
| mc | output | 1 | Modulus control: 1 selects divide-by-5, 0 selects divide-by-4 |

## Verification
The bench measures each period length and the number of clocks with `mc` high, and compares them with 288+chan and 161+5*chan. A design that switches modulus one prescaler cycle early or late shows a period that is off by one. The extreme channels 0 and 31 are driven directly: an off-by-one compare at target 63 would miss the only divide-by-4 cycle, or leave `mc` low across the wrap. During every period the channel input is changed to an unrelated value. A design that samples it continuously produces a period that matches neither channel. The first period after reset is also checked against the reset channel of 0.

// File: rtl/moddiv_pkg.sv
package moddiv_pkg;
   typedef enum logic {
      MOD_LOW  = 1'b0,
      MOD_HIGH = 1'b1
   } modsel_e;

   function automatic int unsigned period_len(int unsigned lo, int unsigned cw, int unsigned ch);
      int unsigned half;
      half = 1 << (cw - 1);
      return (lo + 1) * (half + ch) + lo * (half - ch);
   endfunction
endpackage

// File: rtl/moddiv_prescaler.sv
module moddiv_prescaler #(
   parameter int unsigned PRE_LO = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mc,
   output logic tc
);
   localparam int unsigned PRE_HI = PRE_LO + 1;
   localparam int unsigned PW     = $clog2(PRE_HI);

   generate
      if (PRE_LO < 2) begin : g_bad_lo
         $error("moddiv_prescaler: PRE_LO must be at least 2");
      end
   endgenerate

   logic [PW-1:0] ph;
   logic [PW-1:0] last;

   assign last = mc ? PW'(PRE_HI - 1) : PW'(PRE_LO - 1);
   assign tc   = (ph == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ph <= '0;
      else if (tc) ph <= '0;
      else         ph <= ph + 1'b1;
   end

   assert_phase_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mc ? (ph < PW'(PRE_HI)) : (ph < PW'(PRE_LO)));

   assert_cycle_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tc |=> (ph == '0));
endmodule

// File: rtl/moddiv_progcnt.sv
module moddiv_progcnt #(
   parameter int unsigned CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   generate
      if (CNT_W < 2) begin : g_bad_w
         $error("moddiv_progcnt: CNT_W must be at least 2");
      end
   endgenerate

   assign wrap = adv && (cnt == {CNT_W{1'b1}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (adv) cnt <= cnt + 1'b1;
   end

   assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> (cnt == $past(cnt) + 1'b1));

   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(cnt));
endmodule

// File: rtl/moddiv_modctl.sv
module moddiv_modctl #(
   parameter int unsigned CNT_W    = 6,
   parameter int unsigned CH_W     = 5,
   parameter bit          XNOR_CMP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   input  logic             wrap,
   input  logic [CH_W-1:0]  chan_in,
   output logic [CH_W-1:0]  chan_q,
   output logic             mc
);
   import moddiv_pkg::*;

   generate
      if (CH_W + 1 != CNT_W) begin : g_bad_ch
         $error("moddiv_modctl: CH_W must equal CNT_W-1");
      end
   endgenerate

   logic [CNT_W-1:0] target;
   logic             hit;
   logic             sw;

   assign target = {1'b1, chan_q};

   generate
      if (XNOR_CMP) begin : g_xnor
         logic [CNT_W-1:0] eq_bit;
         for (genvar i = 0; i < CNT_W; i++) begin : g_bit
            assign eq_bit[i] = ~(cnt[i] ^ target[i]);
         end
         assign hit = &eq_bit;
      end else begin : g_direct
         assign hit = (cnt == target);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sw     <= 1'b0;
         chan_q <= '0;
      end else if (wrap) begin
         sw     <= 1'b0;
         chan_q <= chan_in;
      end else if (hit) begin
         sw     <= 1'b1;
      end
   end

   assign mc = sw ? MOD_LOW : MOD_HIGH;

   assert_switch_at_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mc) |-> (cnt == {1'b1, chan_q}));

   assert_restore_at_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mc) |-> (cnt == '0));

   assert_chan_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> $stable(chan_q));
endmodule

// File: rtl/moddiv_channel_divider.sv
module moddiv_channel_divider #(
   parameter int unsigned PRE_LO   = 4,
   parameter int unsigned CNT_W    = 6,
   parameter int unsigned CH_W     = CNT_W - 1,
   parameter bit          XNOR_CMP = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [CH_W-1:0] chan,
   output logic            div_out,
   output logic            mc
);
   logic             pre_tc;
   logic             wrap;
   logic [CNT_W-1:0] cnt;
   logic [CH_W-1:0]  chan_q;

   moddiv_prescaler #(.PRE_LO(PRE_LO)) u_pre (
      .clk(clk), .rst_n(rst_n), .mc(mc), .tc(pre_tc)
   );

   moddiv_progcnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .adv(pre_tc), .cnt(cnt), .wrap(wrap)
   );

   moddiv_modctl #(.CNT_W(CNT_W), .CH_W(CH_W), .XNOR_CMP(XNOR_CMP)) u_ctl (
      .clk(clk), .rst_n(rst_n), .cnt(cnt), .wrap(wrap),
      .chan_in(chan), .chan_q(chan_q), .mc(mc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) div_out <= 1'b0;
      else        div_out <= wrap;
   end

   assert_pulse_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      div_out |-> (cnt == '0));

   assert_pulse_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
      div_out |=> !div_out);

   assert_mode_at_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
      div_out |-> mc);
endmodule

// File: tb/sim_moddiv_channel_divider.sv
module sim_moddiv_channel_divider;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] chan = 5'd0;
   logic       div_out;
   logic       mc;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   moddiv_channel_divider u0 (
      .clk(clk), .rst_n(rst_n), .chan(chan), .div_out(div_out), .mc(mc)
   );

   function automatic int exp_period(int c);
      return 288 + c;
   endfunction

   function automatic int exp_mc_high(int c);
      return 161 + 5 * c;
   endfunction

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Measures one period starting at a pulse (sampled at negedge).
   // cur: channel in effect; nxt: channel for the following period.
   task automatic run_period(int cur, int nxt, string req);
      int n;
      int hi;
      int w;
      n  = 0;
      hi = 0;
      w  = 0;
      chan = 5'(~nxt);
      do begin
         if (mc) hi++;
         if (div_out) w++;
         n++;
         if (n == 100) chan = 5'(nxt ^ 5'h15);
         if (n == 200) chan = 5'(nxt);
         @(negedge clk);
      end while (!div_out && n < 2000);
      chk({req, " R6 period"}, n, exp_period(cur));
      chk({req, " R4 mc-high clocks"}, hi, exp_mc_high(cur));
      chk({req, " R7 pulse width"}, w, 1);
      chk({req, " R8 mid-period chan ignored"}, n, exp_period(cur));
   endtask

   initial begin
      int n;
      int cur;
      int nxt;
      int dir[3] = '{0, 31, 17};
      void'($urandom(32'd1234));
      #1;
      chk("R1 div_out in reset", int'(div_out), 0);
      chk("R1 mc in reset", int'(mc), 1);
      @(negedge clk);
      rst_n = 1'b1;
      chan  = 5'd0;
      @(negedge clk);
      n = 1;
      chk("R1 div_out after release", int'(div_out), 0);
      chk("R1 mc after release", int'(mc), 1);
      chan = 5'd9;
      while (!div_out && n < 2000) begin
         @(negedge clk);
         n++;
         if (n == 150) chan = 5'd0;
      end
      chk("R9 first pulse edge", n, 288);
      cur = 0;
      for (int i = 0; i < 3; i++) begin
         nxt = dir[i];
         run_period(cur, nxt, (cur == 0 || cur == 31) ? "R10" : "R3");
         cur = nxt;
      end
      for (int i = 0; i < 10; i++) begin
         nxt = int'($urandom_range(0, 31));
         run_period(cur, nxt, "R2");
         cur = nxt;
      end
      run_period(cur, 0, "R5");
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule